// File: doc/BRIEF.md
# Low-Power Quiesce Handshake Controller

This block runs the handshake between a processor that wants to enter a low-power state and the bus logic that must first go quiet. The processor raises a quiesce request at any moment, with no relation to the bus clock. The controller brings that request into the bus clock domain through a multi-stage synchronizer. It then closes a gate that stops new snoop-requiring transactions from being accepted. It waits until every transaction already in flight has completed. Only then does it raise the acknowledge, which tells the processor it may power down.

The controller tracks in-flight work with a saturating counter. The bus logic pulses `txn_start` when a snoop-requiring transaction is accepted and `txn_done` when one finishes. An optional external busy input can extend the notion of "still active". The acknowledge drops when the processor withdraws its request. It also drops when a wake event arrives, even if the request is still held. Once wake clears, a request that is still asserted causes the drain to run again before the acknowledge can return.

Top module: `quiesce_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, `quiesce_ack` is 0 and `txn_gate_open` is 1.
- R2: A request that is set between clock edges closes the gate (`txn_gate_open` falls) on the third rising edge after it is set. That is two synchronizer stages plus the state register. With nothing outstanding, `quiesce_ack` rises one edge later.
- R3: `quiesce_ack` is 1 only while the synchronized request is 1. Once the raw request drops, `quiesce_ack` falls on the third rising edge.
- R4: `quiesce_ack` never rises while the outstanding count is non-zero or `ext_busy` is 1. During a drain, it rises on the edge after both conditions clear.
- R5: `txn_gate_open` is 0 whenever the controller is draining or quiesced (including whenever `quiesce_ack` is 1), and 1 in full-on operation.
- R6: If the request is withdrawn during a drain, the controller returns to full-on, the gate reopens, and `quiesce_ack` never rises.
- R7: A `wake` of 1 forces full-on on the next edge. `quiesce_ack` falls and the gate opens, even with the request held. While `wake` stays 1 no drain starts. After it clears, a held request restarts the drain and `quiesce_ack` returns once idle.
- R8: The outstanding count rises by one on `txn_start` and falls by one on `txn_done`; the two together leave it unchanged. A `txn_done` at count zero is ignored. A `txn_start` at the maximum count of 2^CNT_W-1 is ignored (saturation). A start is counted even while the gate is closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quiesce_req_async | input | 1 | Quiesce request from the processor, asynchronous |
| wake | input | 1 | Internal wake event, forces full-on |
| txn_start | input | 1 | A snoop-requiring transaction was accepted |
| txn_done | input | 1 | A snoop-requiring transaction completed |
| ext_busy | input | 1 | Extra activity indication, counted as not drained |
| quiesce_ack | output | 1 | Quiesce acknowledge, processor may enter low power |
| txn_gate_open | output | 1 | 1 allows new snoop-requiring transactions |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Request withdrawn mid-drain.** A controller that latched the request would raise the acknowledge anyway.
- **Wake with the request still held.** A design that ignored wake would keep the acknowledge up. One that never re-drained would leave the processor stuck at full-on.
- **Completion at count zero, and starts past the counter maximum.** A wrapping counter would either claim idle with work still in flight, or never reach idle.
- **Acknowledge timing.** The bench checks the exact synchronizer latency and confirms the acknowledge waits for `ext_busy` and for the final completion. An early acknowledge lets the processor sleep while snoops are still pending.

// File: rtl/qc_pkg.sv
package qc_pkg;

   typedef enum logic [1:0] {
      ST_FULL_ON  = 2'd0,
      ST_DRAINING = 2'd1,
      ST_QUIESCED = 2'd2
   } qc_state_e;

   function automatic logic gate_for(qc_state_e st);
      return (st == ST_FULL_ON);
   endfunction

   function automatic logic ack_for(qc_state_e st);
      return (st == ST_QUIESCED);
   endfunction

endpackage

// File: rtl/qc_sync.sv
module qc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("qc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/qc_drain_mon.sv
module qc_drain_mon #(
   parameter int CNT_W       = 4,
   parameter bit USE_BUSY_IN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             txn_start,
   input  logic             txn_done,
   input  logic             ext_busy,
   output logic [CNT_W-1:0] outstanding,
   output logic             drained
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_width
      $error("qc_drain_mon: CNT_W out of range 1..16");
   end

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             busy_term;

   always_comb begin
      cnt_d = cnt_q;
      unique case ({txn_start, txn_done})
         2'b10:   if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
         2'b01:   if (cnt_q != '0)      cnt_d = cnt_q - 1'b1;
         default: cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   if (USE_BUSY_IN) begin : g_busy
      assign busy_term = ext_busy;
   end else begin : g_no_busy
      logic unused_busy;
      assign unused_busy = ext_busy;
      assign busy_term   = 1'b0;
   end

   assign outstanding = cnt_q;
   assign drained     = (cnt_q == '0) && !busy_term;

endmodule

// File: rtl/qc_fsm.sv
module qc_fsm
   import qc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_sync,
   input  logic      wake,
   input  logic      drained,
   output qc_state_e state,
   output logic      ack,
   output logic      gate_open
);

   qc_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_FULL_ON:  if (req_sync && !wake) st_d = ST_DRAINING;
         ST_DRAINING: begin
            if (!req_sync || wake) st_d = ST_FULL_ON;
            else if (drained)      st_d = ST_QUIESCED;
         end
         ST_QUIESCED: if (!req_sync || wake) st_d = ST_FULL_ON;
         default:     st_d = ST_FULL_ON;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_FULL_ON;
      else        st_q <= st_d;
   end

   assign state     = st_q;
   assign ack       = ack_for(st_q);
   assign gate_open = gate_for(st_q);

endmodule

// File: rtl/quiesce_ctrl.sv
module quiesce_ctrl
   import qc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 4,
   parameter bit USE_BUSY_IN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic quiesce_req_async,
   input  logic wake,
   input  logic txn_start,
   input  logic txn_done,
   input  logic ext_busy,
   output logic quiesce_ack,
   output logic txn_gate_open
);

   logic             req_sync;
   logic             drained;
   logic [CNT_W-1:0] outstanding;
   qc_state_e        state;

   qc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (quiesce_req_async),
      .q_sync  (req_sync)
   );

   qc_drain_mon #(.CNT_W(CNT_W), .USE_BUSY_IN(USE_BUSY_IN)) u_drain (
      .clk         (clk),
      .rst_n       (rst_n),
      .txn_start   (txn_start),
      .txn_done    (txn_done),
      .ext_busy    (ext_busy),
      .outstanding (outstanding),
      .drained     (drained)
   );

   qc_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_sync  (req_sync),
      .wake      (wake),
      .drained   (drained),
      .state     (state),
      .ack       (quiesce_ack),
      .gate_open (txn_gate_open)
   );

endmodule

// File: rtl/quiesce_ctrl_checker.sv
module quiesce_ctrl_checker #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_sync,
   input logic             drained,
   input logic             wake,
   input logic             txn_start,
   input logic             txn_done,
   input logic [CNT_W-1:0] outstanding,
   input logic             quiesce_ack,
   input logic             txn_gate_open
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      quiesce_ack |-> $past(req_sync)); // R3

   AST_ACK_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(quiesce_ack) |-> $past(drained)); // R4

   AST_GATE_SHUT_WHEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      quiesce_ack |-> !txn_gate_open); // R5

   AST_GATE_CLOSE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(txn_gate_open) |-> $past(req_sync)); // R2

   AST_WAKE_DROPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (wake && quiesce_ack) |=> !quiesce_ack); // R7

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (outstanding == CNT_MAX && txn_start && !txn_done) |=> (outstanding == CNT_MAX)); // R8

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (outstanding == '0 && txn_done && !txn_start) |=> (outstanding == '0)); // R8

endmodule

bind quiesce_ctrl quiesce_ctrl_checker #(.CNT_W(CNT_W)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_sync      (req_sync),
   .drained       (drained),
   .wake          (wake),
   .txn_start     (txn_start),
   .txn_done      (txn_done),
   .outstanding   (outstanding),
   .quiesce_ack   (quiesce_ack),
   .txn_gate_open (txn_gate_open)
);

// File: tb/test_quiesce_ctrl.sv
module test_quiesce_ctrl;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, wake = 1'b0, start = 1'b0, done = 1'b0, busy = 1'b0;
   logic ack, gate;
   int   checks = 0, fails = 0;
   bit   finished = 1'b0;

   always #2 clk = ~clk;

   quiesce_ctrl i_quiesce_ctrl (
      .clk               (clk),
      .rst_n             (rst_n),
      .quiesce_req_async (req),
      .wake              (wake),
      .txn_start         (start),
      .txn_done          (done),
      .ext_busy          (busy),
      .quiesce_ack       (ack),
      .txn_gate_open     (gate)
   );

   // row bits: {req, wake, start, done, busy, exp_ack, exp_gate}
   localparam int NV = 37;
   localparam logic [6:0] VEC [NV] = '{
      7'b1000001, 7'b1010001, 7'b1000000, 7'b1000000, 7'b1001000, // R2 R4
      7'b1000100, 7'b1000010, 7'b1100001, 7'b1100001, 7'b1000000, // R4 R7
      7'b1000010, 7'b0000010, 7'b0000010, 7'b0000001, 7'b1010001, // R3
      7'b1000001, 7'b0000000, 7'b0000000, 7'b0000001, 7'b0001001, // R6
      7'b0001001, 7'b1011001, 7'b1000001, 7'b1000000, 7'b1000010, // R8
      7'b0000010, 7'b0000010, 7'b0000001, 7'b1010001, 7'b1000001,
      7'b1000000, 7'b1100001, 7'b1001000, 7'b1000010, 7'b0000010, // R7
      7'b0000010, 7'b0000001
   };

   task automatic check(input string req_tag, input logic exp_ack, input logic exp_gate);
      checks++;
      if (ack !== exp_ack || gate !== exp_gate) begin
         fails++;
         $display("FAIL %s: ack=%b gate=%b expected ack=%b gate=%b", req_tag, ack, gate, exp_ack, exp_gate);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 in reset", 1'b0, 1'b1);
      rst_n = 1'b1;
      step();
      check("R1 after release", 1'b0, 1'b1);

      for (int i = 0; i < NV; i++) begin
         {req, wake, start, done, busy} = VEC[i][6:2];
         step();
         check($sformatf("R2-table row %0d (R3 R4 R5 R6 R7 R8)", i), VEC[i][1], VEC[i][0]);
      end

      // R8: saturation at the counter maximum, 20 starts then 14 completions
      {req, wake, start, done, busy} = 5'b00100;
      repeat (20) step();
      {start, done} = 2'b01;
      repeat (14) step();
      {req, done} = 2'b10;
      repeat (5) step();
      check("R8 saturated count keeps drain open", 1'b0, 1'b0);
      // R8: start while gate closed is counted
      start = 1'b1;
      step();
      start = 1'b0;
      {done} = 1'b1;
      step();
      step();
      check("R8 start under closed gate counted", 1'b0, 1'b0);
      done = 1'b0;
      step();
      check("R4 ack after final completion", 1'b1, 1'b0);

      // R1: reset while quiesced
      #1 rst_n = 1'b0;
      #1 check("R1 reset during quiesce", 1'b0, 1'b1);
      req = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      step();
      check("R1 after second release", 1'b0, 1'b1);

      finish_run();
   end

endmodule